// File: doc/BRIEF.md
# Eight-Channel Down-Counting Timer Bank

This block is an APB register slave holding a bank of independent down-counters that share one address window. Each channel has four words of its own (a load value, the live count, a control word and a clear-on-read acknowledge word), plus a word that reflects its gated interrupt. Four words after the last channel cover the whole bank: gated interrupt status, acknowledge-all, ungated (raw) status and a fixed version constant. The counters run on the APB clock and step once for each cycle in which `tick_en` is high.

Each channel counts toward zero. A channel expires when its count is zero at a tick. On expiry the channel either wraps to all ones (free-running mode) or reloads the value it captured when it was last started (periodic mode), and it sets its raw status bit. Each channel drives an interrupt line. The line is high while that raw bit is set and the channel's mask bit is clear. Software acknowledges an interrupt by reading the channel's acknowledge word, or the shared acknowledge-all word. A new load value written while a channel runs waits in the load register until the channel is next started.

Top module: `tmr_bank`

## Requirements
- R1: After reset every load, count and control word reads 0. The raw status and the gated status read 0, and every `irq` bit is low.
- R2: Writing the control word with run (bit 0) set, while the channel is stopped, copies the load word into the count. From then on the count drops by one for each cycle with `tick_en` high.
- R3: A stopped channel, or any channel in a cycle with `tick_en` low, keeps its count and sets no raw status bit.
- R4: In free-running mode (control bit 1 = 0), a tick that finds the count at 0 sets the count to 0xFFFFFFFF and sets the channel's raw status bit.
- R5: In periodic mode (control bit 1 = 1), expiry reloads the value captured at the last start. A load write while running changes what the load word reads back, but it reaches neither the live count nor the reload value until the next start.
- R6: The raw status word (0xA8) has one bit per channel, bit i for channel i. Expiry sets the bit whether or not the channel's mask (control bit 2) is set.
- R7: `irq[i]` is high exactly when raw bit i is set and mask bit i is clear. Bit 0 of channel offset 0x10, and bit i of the shared word at 0xA0, read the same gated value.
- R8: A read of channel offset 0x0C returns 0 and clears only that channel's raw bit. A read of 0xA4 returns 0 and clears every raw bit.
- R9: When an acknowledge read and an expiry of the same channel fall in the same cycle, the raw bit stays set.
- R10: Channel i's words start at i*0x14, with load at +0x00, count at +0x04 and control at +0x08. The version word at 0xAC always reads the VERSION parameter and ignores writes. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock; also clocks the counters |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | AW | APB byte address |
| pwdata | input | CW | APB write data |
| prdata | output | CW | APB read data, valid in the access phase |
| tick_en | input | 1 | Count enable, one step per high cycle |
| irq | output | NUM_TMR | Gated interrupt per channel |

## Verification
The bench sweeps all eight channels. For each one it checks the count after a start, after a few ticks, at zero and one tick after that, so a design that expires one tick early or late, or that reloads on a tick instead of on the start, shows a wrong count. A masked free-running expiry must still set the raw bit while `irq` stays low, which catches status that is gated by the mask. A load written while a channel runs must not reach the periodic reload, so a design that reloads from the live load word fails. An acknowledge that lands in the same cycle as an expiry must leave the bit set, so a design that gives the clear priority would lose that interrupt.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;

  // control word: bit0 run, bit1 periodic, bit2 irq_mask
  typedef struct packed {
    logic irq_mask;
    logic periodic;
    logic run;
  } tmr_ctrl_t;

  typedef enum logic [3:0] {
    RK_NONE,
    RK_LOAD,
    RK_CUR,
    RK_CTRL,
    RK_ACK,
    RK_GSTAT,
    RK_ALL_GSTAT,
    RK_ALL_ACK,
    RK_ALL_RAW,
    RK_VERSION
  } reg_kind_e;

  localparam int unsigned CH_STRIDE  = 20;
  localparam int unsigned OFF_LOAD   = 0;
  localparam int unsigned OFF_CUR    = 4;
  localparam int unsigned OFF_CTRL   = 8;
  localparam int unsigned OFF_ACK    = 12;
  localparam int unsigned OFF_GSTAT  = 16;
  localparam int unsigned SH_GSTAT   = 0;
  localparam int unsigned SH_ACK     = 4;
  localparam int unsigned SH_RAW     = 8;
  localparam int unsigned SH_VERSION = 12;

endpackage

// File: rtl/tmr_bank_decode.sv
module tmr_bank_decode
  import tmr_bank_pkg::*;
#(
  parameter int NUM = 8,
  parameter int AW  = 8,
  localparam int IW = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic            psel,
  input  logic            penable,
  input  logic            pwrite,
  input  logic [AW-1:0]   paddr,
  output reg_kind_e       kind,
  output logic [IW-1:0]   chan,
  output logic [NUM-1:0]  wr_load,
  output logic [NUM-1:0]  wr_ctrl,
  output logic [NUM-1:0]  rd_ack,
  output logic            rd_ack_all
);

  localparam int unsigned SH_BASE = NUM * CH_STRIDE;

  logic acc_wr;
  logic acc_rd;

  always_comb begin
    kind = RK_NONE;
    chan = '0;
    for (int i = 0; i < NUM; i++) begin
      if (paddr == AW'(i * CH_STRIDE + OFF_LOAD)) begin
        kind = RK_LOAD;  chan = IW'(i);
      end
      if (paddr == AW'(i * CH_STRIDE + OFF_CUR)) begin
        kind = RK_CUR;   chan = IW'(i);
      end
      if (paddr == AW'(i * CH_STRIDE + OFF_CTRL)) begin
        kind = RK_CTRL;  chan = IW'(i);
      end
      if (paddr == AW'(i * CH_STRIDE + OFF_ACK)) begin
        kind = RK_ACK;   chan = IW'(i);
      end
      if (paddr == AW'(i * CH_STRIDE + OFF_GSTAT)) begin
        kind = RK_GSTAT; chan = IW'(i);
      end
    end
    if (paddr == AW'(SH_BASE + SH_GSTAT))   kind = RK_ALL_GSTAT;
    if (paddr == AW'(SH_BASE + SH_ACK))     kind = RK_ALL_ACK;
    if (paddr == AW'(SH_BASE + SH_RAW))     kind = RK_ALL_RAW;
    if (paddr == AW'(SH_BASE + SH_VERSION)) kind = RK_VERSION;
  end

  assign acc_wr = psel && penable && pwrite;
  assign acc_rd = psel && penable && !pwrite;

  always_comb begin
    for (int i = 0; i < NUM; i++) begin
      wr_load[i] = acc_wr && (kind == RK_LOAD) && (chan == IW'(i));
      wr_ctrl[i] = acc_wr && (kind == RK_CTRL) && (chan == IW'(i));
      rd_ack[i]  = acc_rd && (kind == RK_ACK)  && (chan == IW'(i));
    end
    rd_ack_all = acc_rd && (kind == RK_ALL_ACK);
  end

endmodule

// File: rtl/tmr_bank_chan.sv
module tmr_bank_chan
  import tmr_bank_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          wr_load,
  input  logic          wr_ctrl,
  input  logic [CW-1:0] wdata,
  input  logic          ack_clr,
  output logic [CW-1:0] load_q,
  output logic [CW-1:0] cnt_q,
  output tmr_ctrl_t     ctrl_q,
  output logic          raw_q
);

  logic [CW-1:0] load_n;
  logic [CW-1:0] cnt_n;
  logic [CW-1:0] act_q;
  logic [CW-1:0] act_n;
  tmr_ctrl_t     ctrl_n;
  logic          raw_n;
  logic          start;
  logic          step;
  logic          expire;

  always_comb begin
    load_n = wdata;
    ctrl_n = tmr_ctrl_t'(wdata[2:0]);
    start  = wr_ctrl && wdata[0] && !ctrl_q.run;
    step   = ctrl_q.run && tick_en;
    expire = step && (cnt_q == '0);
    act_n  = act_q;
    cnt_n  = cnt_q;
    if (start) begin
      cnt_n = load_q;
      act_n = load_q;
    end else if (expire) begin
      cnt_n = ctrl_q.periodic ? act_q : '1;
    end else if (step) begin
      cnt_n = cnt_q - 1'b1;
    end
    // a new expiry wins over a clear in the same cycle
    raw_n = expire || (raw_q && !ack_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      ctrl_q <= '0;
      cnt_q  <= '0;
      act_q  <= '0;
      raw_q  <= 1'b0;
    end else begin
      if (wr_load) load_q <= load_n;
      if (wr_ctrl) ctrl_q <= ctrl_n;
      if (start || step) cnt_q <= cnt_n;
      if (start) act_q <= act_n;
      if (expire || ack_clr) raw_q <= raw_n;
    end
  end

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_bank_pkg::*;
#(
  parameter int NUM_TMR = 8,
  parameter int CW      = 32,
  parameter int AW      = 8,
  parameter logic [CW-1:0] VERSION = CW'(32'h5445_0103)
) (
  input  logic               pclk,
  input  logic               presetn,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [AW-1:0]      paddr,
  input  logic [CW-1:0]      pwdata,
  output logic [CW-1:0]      prdata,
  input  logic               tick_en,
  output logic [NUM_TMR-1:0] irq
);

  localparam int IW = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1;

  reg_kind_e                   kind;
  logic [IW-1:0]               chan;
  logic [NUM_TMR-1:0]          wr_load;
  logic [NUM_TMR-1:0]          wr_ctrl;
  logic [NUM_TMR-1:0]          rd_ack;
  logic                        rd_ack_all;
  logic [NUM_TMR-1:0][CW-1:0]  load_pk;
  logic [NUM_TMR-1:0][CW-1:0]  cnt_pk;
  tmr_ctrl_t [NUM_TMR-1:0]     ctrl_pk;
  logic [NUM_TMR-1:0]          en_v;
  logic [NUM_TMR-1:0]          mode_v;
  logic [NUM_TMR-1:0]          mask_v;
  logic [NUM_TMR-1:0]          raw_v;

  tmr_bank_decode #(.NUM(NUM_TMR), .AW(AW)) u_dec (
    .psel       (psel),
    .penable    (penable),
    .pwrite     (pwrite),
    .paddr      (paddr),
    .kind       (kind),
    .chan       (chan),
    .wr_load    (wr_load),
    .wr_ctrl    (wr_ctrl),
    .rd_ack     (rd_ack),
    .rd_ack_all (rd_ack_all)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_ch
    tmr_bank_chan #(.CW(CW)) u_ch (
      .clk     (pclk),
      .rst_n   (presetn),
      .tick_en (tick_en),
      .wr_load (wr_load[g]),
      .wr_ctrl (wr_ctrl[g]),
      .wdata   (pwdata),
      .ack_clr (rd_ack[g] || rd_ack_all),
      .load_q  (load_pk[g]),
      .cnt_q   (cnt_pk[g]),
      .ctrl_q  (ctrl_pk[g]),
      .raw_q   (raw_v[g])
    );
    assign en_v[g]   = ctrl_pk[g].run;
    assign mode_v[g] = ctrl_pk[g].periodic;
    assign mask_v[g] = ctrl_pk[g].irq_mask;
  end

  assign irq = raw_v & ~mask_v;

  always_comb begin
    prdata = '0;
    case (kind)
      RK_LOAD:      prdata = load_pk[chan];
      RK_CUR:       prdata = cnt_pk[chan];
      RK_CTRL:      prdata = CW'(ctrl_pk[chan]);
      RK_GSTAT:     prdata = CW'(irq[chan]);
      RK_ALL_GSTAT: prdata = CW'(irq);
      RK_ALL_RAW:   prdata = CW'(raw_v);
      RK_VERSION:   prdata = VERSION;
      default:      prdata = '0;
    endcase
  end

endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
  parameter int NUM = 8,
  parameter int CW  = 32,
  parameter int AW  = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  psel,
  input logic                  penable,
  input logic                  pwrite,
  input logic [AW-1:0]         paddr,
  input logic [CW-1:0]         prdata,
  input logic                  tick_en,
  input logic [NUM-1:0]        irq,
  input logic [NUM-1:0]        en_v,
  input logic [NUM-1:0]        mode_v,
  input logic [NUM-1:0]        mask_v,
  input logic [NUM-1:0]        raw_v,
  input logic [NUM-1:0][CW-1:0] cnt_pk,
  input logic [NUM-1:0][CW-1:0] load_pk
);

  logic wr_any;
  assign wr_any = psel && penable && pwrite;

  for (genvar g = 0; g < NUM; g++) begin : g_p
    localparam logic [AW-1:0] ACK_A = AW'(g * 20 + 12);

    p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_v[g]) |-> cnt_pk[g] == $past(load_pk[g]));

    p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !wr_any) |=> $stable(cnt_pk[g]));

    p_raw_needs_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_v[g]) |-> $past(en_v[g] && tick_en));

    p_free_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en_v[g] && !mode_v[g] && tick_en && cnt_pk[g] == '0 && !wr_any)
      |=> (cnt_pk[g] == '1) && raw_v[g]);

    p_mask_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mask_v[g] |-> !irq[g]);

    p_ack_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable && !pwrite && paddr == ACK_A) |-> prdata == '0);
  end

endmodule

bind tmr_bank tmr_bank_chk #(.NUM(NUM_TMR), .CW(CW), .AW(AW)) u_chk (
  .clk     (pclk),
  .rst_n   (presetn),
  .psel    (psel),
  .penable (penable),
  .pwrite  (pwrite),
  .paddr   (paddr),
  .prdata  (prdata),
  .tick_en (tick_en),
  .irq     (irq),
  .en_v    (en_v),
  .mode_v  (mode_v),
  .mask_v  (mask_v),
  .raw_v   (raw_v),
  .cnt_pk  (cnt_pk),
  .load_pk (load_pk)
);

// File: tb/tmr_bank_bench.sv
module tmr_bank_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NT = 8;
  localparam logic [31:0] VER = 32'h5445_0103;

  logic        pclk;
  logic        presetn;
  logic        psel;
  logic        penable;
  logic        pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        tick_en;
  logic [NT-1:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  tmr_bank u_tmr_bank (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .tick_en(tick_en), .irq(irq)
  );

  initial pclk = 1'b0;
  always #(CLK_PERIOD / 2) pclk = ~pclk;

  function automatic logic [7:0] ra(input int ch, input int off);
    return 8'(ch * 20 + off);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    psel = 1; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic tk, output logic [31:0] d);
    psel = 1; pwrite = 0; paddr = a;
    @(negedge pclk); penable = 1; tick_en = tk;
    #1 d = prdata;
    @(negedge pclk); psel = 0; penable = 0; tick_en = 0;
  endtask

  task automatic tick(input int n);
    tick_en = 1;
    repeat (n) @(negedge pclk);
    tick_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0; tick_en = 0;
    presetn = 0;
    repeat (3) @(negedge pclk);
    presetn = 1;
    @(negedge pclk);

    // R1 reset state across every channel
    for (int c = 0; c < NT; c++) begin
      rd(ra(c, 0), 0, d);  check("R1 load", d, 0);
      rd(ra(c, 4), 0, d);  check("R1 count", d, 0);
      rd(ra(c, 8), 0, d);  check("R1 ctrl", d, 0);
    end
    rd(8'hA8, 0, d); check("R1 raw", d, 0);
    rd(8'hA0, 0, d); check("R1 gated", d, 0);
    check("R1 irq", 32'(irq), 0);
    rd(8'hAC, 0, d); check("R10 version", d, VER);

    // R2 R4-periodic R6 R8 sweep: each channel periodic, unmasked
    for (int c = 0; c < NT; c++) begin
      int l = 5 + c;
      wr(ra(c, 0), 32'(l));
      wr(ra(c, 8), 32'h3);
      rd(ra(c, 8), 0, d); check("R10 ctrl readback", d, 3);
      rd(ra(c, 4), 0, d); check("R2 start load", d, 32'(l));
      tick(3);
      rd(ra(c, 4), 0, d); check("R2 decrement", d, 32'(l - 3));
      tick(l - 3);
      rd(ra(c, 4), 0, d); check("R2 at zero", d, 0);
      rd(8'hA8, 0, d);    check("R6 no early expiry", d, 0);
      tick(1);
      rd(ra(c, 4), 0, d); check("R5 periodic reload", d, 32'(l));
      rd(8'hA8, 0, d);    check("R6 raw bit", d, 32'(1 << c));
      check("R7 irq line", 32'(irq), 32'(1 << c));
      rd(ra(c, 16), 0, d); check("R7 channel gated", d, 1);
      rd(ra(c, 12), 0, d); check("R8 ack reads zero", d, 0);
      rd(8'hA8, 0, d);    check("R8 ack clears", d, 0);
      check("R8 irq low", 32'(irq), 0);
      wr(ra(c, 8), 0);
    end

    // R4 R6 R7: free-running, masked
    wr(ra(3, 0), 2);
    wr(ra(3, 8), 32'h5);
    tick(3);
    rd(ra(3, 4), 0, d); check("R4 wrap to ones", d, 32'hFFFF_FFFF);
    rd(8'hA8, 0, d);    check("R6 raw while masked", d, 32'h8);
    check("R7 masked irq", 32'(irq), 0);
    rd(8'hA0, 0, d);    check("R7 gated masked", d, 0);
    rd(ra(3, 16), 0, d); check("R7 channel gated masked", d, 0);
    tick(1);
    rd(ra(3, 4), 0, d); check("R4 continue after wrap", d, 32'hFFFF_FFFE);
    wr(ra(3, 8), 32'h1);
    check("R7 unmasked irq", 32'(irq), 32'h8);
    rd(8'hA0, 0, d);    check("R7 gated unmasked", d, 32'h8);
    rd(ra(3, 4), 0, d); check("R2 no restart while running", d, 32'hFFFF_FFFE);
    wr(ra(3, 8), 0);
    rd(ra(3, 12), 0, d);

    // R5 load write while running
    wr(ra(5, 0), 4);
    wr(ra(5, 8), 32'h3);
    wr(ra(5, 0), 10);
    rd(ra(5, 0), 0, d); check("R5 load readback", d, 10);
    rd(ra(5, 4), 0, d); check("R5 count untouched", d, 4);
    tick(5);
    rd(ra(5, 4), 0, d); check("R5 reload old value", d, 4);
    wr(ra(5, 8), 0);
    wr(ra(5, 8), 32'h3);
    rd(ra(5, 4), 0, d); check("R5 new value on restart", d, 10);
    wr(ra(5, 8), 0);
    rd(ra(5, 12), 0, d);

    // R3 stopped channel holds
    wr(ra(6, 0), 7);
    wr(ra(6, 8), 32'h3);
    tick(2);
    rd(ra(6, 4), 0, d); check("R3 running count", d, 5);
    wr(ra(6, 8), 0);
    tick(20);
    rd(ra(6, 4), 0, d); check("R3 stopped holds", d, 5);
    rd(8'hA8, 0, d);    check("R3 no raw when stopped", d, 0);
    wr(ra(6, 8), 32'h1);
    repeat (4) @(negedge pclk);
    rd(ra(6, 4), 0, d); check("R3 no tick holds", d, 7);
    wr(ra(6, 8), 0);

    // R8 acknowledge-all
    wr(ra(0, 0), 0);
    wr(ra(1, 0), 0);
    wr(ra(0, 8), 32'h1);
    wr(ra(1, 8), 32'h1);
    tick(1);
    rd(8'hA8, 0, d);    check("R4 both expire", d, 32'h3);
    check("R7 both irq", 32'(irq), 32'h3);
    rd(ra(1, 4), 0, d); check("R4 zero load wraps", d, 32'hFFFF_FFFF);
    rd(ra(0, 12), 0, d);
    rd(8'hA8, 0, d);    check("R8 only own bit", d, 32'h2);
    rd(8'hA4, 0, d);    check("R8 ack-all reads zero", d, 0);
    rd(8'hA8, 0, d);    check("R8 ack-all clears", d, 0);
    wr(ra(0, 8), 0);
    wr(ra(1, 8), 0);

    // R9 clear colliding with expiry
    wr(ra(2, 0), 0);
    wr(ra(2, 8), 32'h3);
    tick(1);
    rd(8'hA8, 0, d);    check("R9 set", d, 32'h4);
    rd(ra(2, 12), 1, d); check("R9 ack reads zero", d, 0);
    rd(8'hA8, 0, d);    check("R9 expiry wins", d, 32'h4);
    rd(ra(2, 12), 0, d);
    rd(8'hA8, 0, d);    check("R9 later clear", d, 0);
    wr(ra(2, 8), 0);

    // R10 unmapped and read-only
    rd(8'hB0, 0, d);    check("R10 unmapped", d, 0);
    wr(8'hAC, 0);
    rd(8'hAC, 0, d);    check("R10 version read-only", d, VER);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule